// File: doc/BRIEF.md
# Double-Banked 3x3 Kernel Coefficient Store

This block keeps two complete sets of nine coefficients for a 3x3 convolution kernel and presents one of them, in parallel, to a multiplier array. Positions are named A through I. A host fills a set by writing nine values in a row to that set's load address. Each set keeps its own write position, so the host does not have to send a position with each write.

One set is always the active one. All nine of its values appear together on a flat output bus. The host can refill the other set while the active one keeps feeding the multipliers. A single write to the select address then swaps the sets at one clock edge, with no lost processing cycle and no mix of old and new taps. Address decoding and strobe synchronisation happen upstream, so a write arrives here as a one-cycle enable with address and data. The reset is asynchronous and active-low, and its release is synchronous to the clock.

Top module: `kernel_bank_store`

## Requirements
- R1: While reset is asserted and after it is released, with no writes made, the active bank is 0 and all nine coefficient outputs are zero.
- R2: A write with address 0 stores the data in bank 0 and a write with address 1 stores it in bank 1. Consecutive writes to one load address fill positions A, B, ... I in turn. Position A appears on `coef_o[7:0]` and position I on `coef_o[71:64]`; in general position k sits at bits [8k+7:8k].
- R3: After position I has been written, the next consecutive write to the same load address goes to position A.
- R4: A write to any address other than a bank's own load address returns that bank's write position to A.
- R5: A write with address 2 makes the bank named by data bit 0 active. From the clock edge that takes the write, all nine outputs come from that bank. The other data bits are ignored.
- R6: Loading the inactive bank leaves all outputs and the active bank unchanged.
- R7: A write to the active bank's load address shows on the written position from the clock edge that takes the write.
- R8: A write with address 3, and any cycle with the write enable low, changes neither the stored coefficients nor the active bank.
- R9: The two banks keep independent contents and write positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_addr_i | input | 2 | 0: load bank 0, 1: load bank 1, 2: bank select, 3: spare |
| wr_data_i | input | 8 | Coefficient data; bit 0 chooses the bank on a select write |
| coef_o | output | 72 | Nine coefficients of the active bank, position A in the low byte |
| active_bank_o | output | 1 | Index of the bank now driving `coef_o` |

## Verification
The bench targets the write-position wrap after I. A design that gets it wrong puts a tenth write into a missing tenth slot or leaves it at I. It also checks that a write elsewhere returns the position to A; without that, a reload started after an interruption would be shifted by some taps. Bank swaps are checked on the edge itself, where a design with a stale or half-registered multiplexer shows a mix of old and new taps for one cycle. Refills of the inactive bank, spare-address writes and select writes with the upper data bits set are interleaved in a long pseudo-random stream. Any leak into the active outputs or the bank choice shows up as a wrong coefficient.

// File: rtl/kbs_pkg.sv
`timescale 1ns/1ps
package kbs_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LOAD0  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOAD1  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SELECT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SPARE  = 2'd3;
endpackage

// File: rtl/kbs_bank.sv
`timescale 1ns/1ps
module kbs_bank #(
  parameter int unsigned COEF_W   = 8,
  parameter int unsigned NUM_TAPS = 9,
  parameter int unsigned BANK_ID  = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [kbs_pkg::ADDR_W-1:0] wr_addr_i,
  input  logic [COEF_W-1:0]          wr_data_i,
  output logic [NUM_TAPS*COEF_W-1:0] taps_o
);
  localparam int unsigned IDX_W = $clog2(NUM_TAPS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);
  localparam logic [kbs_pkg::ADDR_W-1:0] MY_ADDR = kbs_pkg::ADDR_W'(BANK_ID);

  logic             hit;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign hit = wr_en_i && (wr_addr_i == MY_ADDR);

  // write position: advance on own load, wrap after last tap, clear on any other write
  always_comb begin
    idx_d = idx_q;
    if (wr_en_i) begin
      if (hit) idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
      else     idx_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (wr_en_i) idx_q <= idx_d;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic              tap_we;
    logic [COEF_W-1:0] tap_q;
    assign tap_we = hit && (idx_q == IDX_W'(t));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tap_q <= '0;
      else if (tap_we) tap_q <= wr_data_i;
    end
    assign taps_o[t*COEF_W +: COEF_W] = tap_q;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX); // R3
  AST_IDX_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && idx_q != LAST_IDX) |=> idx_q == $past(idx_q) + IDX_W'(1)); // R2
  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && idx_q == LAST_IDX) |=> idx_q == '0); // R3
  AST_IDX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != MY_ADDR) |=> idx_q == '0); // R4
  AST_TAPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(taps_o)); // R8
endmodule

// File: rtl/kbs_select.sv
`timescale 1ns/1ps
module kbs_select (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [kbs_pkg::ADDR_W-1:0] wr_addr_i,
  input  logic                       sel_bit_i,
  output logic                       active_o
);
  logic sel_we, active_d;

  assign sel_we = wr_en_i && (wr_addr_i == kbs_pkg::ADDR_SELECT);

  always_comb begin
    active_d = active_o;
    if (sel_we) active_d = sel_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_o <= 1'b0;
    else if (sel_we) active_o <= active_d;
  end

  AST_SELECT_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we |=> active_o == $past(sel_bit_i)); // R5
  AST_SELECT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we |=> $stable(active_o)); // R8
endmodule

// File: rtl/kernel_bank_store.sv
`timescale 1ns/1ps
module kernel_bank_store #(
  parameter int unsigned COEF_W   = 8,
  parameter int unsigned NUM_TAPS = 9,
  localparam int unsigned BUS_W   = NUM_TAPS * COEF_W,
  localparam int unsigned NUM_BANKS = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [kbs_pkg::ADDR_W-1:0] wr_addr_i,
  input  logic [COEF_W-1:0]          wr_data_i,
  output logic [BUS_W-1:0]           coef_o,
  output logic                       active_bank_o
);
  logic [BUS_W-1:0] bank_taps [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    kbs_bank #(
      .COEF_W   (COEF_W),
      .NUM_TAPS (NUM_TAPS),
      .BANK_ID  (b)
    ) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .taps_o    (bank_taps[b])
    );
  end

  kbs_select i_select (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .sel_bit_i (wr_data_i[0]),
    .active_o  (active_bank_o)
  );

  // whole-bus multiplexer driven by one registered select: all taps swap together
  always_comb begin
    coef_o = bank_taps[active_bank_o];
  end

  AST_INACTIVE_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == {1'b0, ~active_bank_o}) |=> $stable(coef_o) && $stable(active_bank_o)); // R6
  AST_SPARE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == kbs_pkg::ADDR_SPARE) |=> $stable(coef_o)); // R8
  AST_OUT_FROM_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_o == (active_bank_o ? g_bank[1].i_bank.taps_o : g_bank[0].i_bank.taps_o)); // R9
endmodule

// File: tb/test_kernel_bank_store.sv
`timescale 1ns/1ps
module test_kernel_bank_store;
  localparam int COEF_W = 8;
  localparam int TAPS   = 9;

  logic                    clk;
  logic                    rst_n;
  logic                    wr_en;
  logic [1:0]              wr_addr;
  logic [COEF_W-1:0]       wr_data;
  logic [TAPS*COEF_W-1:0]  coef;
  logic                    act;

  int vectors;
  int miscompares;
  bit done;

  logic [COEF_W-1:0] m_bank [2][TAPS];
  int                m_idx  [2];
  logic              m_act;

  kernel_bank_store i_kernel_bank_store (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .coef_o        (coef),
    .active_bank_o (act)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      m_idx[b] = 0;
      for (int t = 0; t < TAPS; t++) m_bank[b][t] = '0;
    end
    m_act = 1'b0;
  endtask

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    for (int b = 0; b < 2; b++) begin
      if (a == 2'(b)) begin
        m_bank[b][m_idx[b]] = d;
        m_idx[b] = (m_idx[b] == TAPS - 1) ? 0 : m_idx[b] + 1;
      end else begin
        m_idx[b] = 0;
      end
    end
    if (a == 2'd2) m_act = d[0];
  endtask

  task automatic check(input string req);
    bit bad;
    bad = 1'b0;
    vectors++;
    if (act !== m_act) begin
      bad = 1'b1;
      $display("FAIL %s active bank: got %0d expected %0d", req, act, m_act);
    end
    for (int t = 0; t < TAPS; t++) begin
      if (coef[t*COEF_W +: COEF_W] !== m_bank[m_act][t]) begin
        bad = 1'b1;
        $display("FAIL %s tap %0d: got %0h expected %0h", req, t,
                 coef[t*COEF_W +: COEF_W], m_bank[m_act][t]);
      end
    end
    if (bad) miscompares++;
  endtask

  // drive at negedge, the following posedge takes it, sample at the next negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    vectors = 0; miscompares = 0; done = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release");

    // R2 R7: fill active bank 0, each tap visible after its write
    for (int i = 0; i < TAPS; i++) wr(2'd0, 8'(i * 17 + 3), "R2_R7 load active bank");
    // R6 R9: fill inactive bank 1, outputs must not move
    for (int i = 0; i < TAPS; i++) wr(2'd1, 8'(255 - i * 13), "R6_R9 load inactive bank");
    // R5: swap and swap back, upper data bits set
    wr(2'd2, 8'hFF, "R5 select bank 1");
    wr(2'd2, 8'hFE, "R5 select bank 0");
    wr(2'd2, 8'h01, "R5 select bank 1 again");
    // R3: ten consecutive writes to inactive bank 0, then view it
    for (int i = 0; i < TAPS + 1; i++) wr(2'd0, 8'(8'hA0 + i), "R3 wrap load");
    wr(2'd2, 8'h00, "R3 view wrapped bank");
    // R4: partial load, interrupted by spare / other-bank / select writes
    for (int i = 0; i < 3; i++) wr(2'd0, 8'(8'h50 + i), "R4 partial load");
    wr(2'd3, 8'h77, "R4_R8 spare write");
    wr(2'd0, 8'h5A, "R4 restart at A after spare");
    wr(2'd0, 8'h5B, "R4 second tap");
    wr(2'd1, 8'h11, "R4 other bank write");
    wr(2'd0, 8'h5C, "R4 restart at A after other bank");
    wr(2'd2, 8'h00, "R4 select write");
    wr(2'd0, 8'h5D, "R4 restart at A after select");
    // R8: spare sweep and disabled-strobe sweep
    for (int d = 0; d < 256; d += 17) wr(2'd3, 8'(d), "R8 spare sweep");
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 2'(a); wr_data = 8'(a * 61 + 1);
      @(negedge clk);
      check("R8 strobe low");
    end
    // mixed pseudo-random stream over all requirements
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0)      wr(2'd2, lfsr[15:8], "R5_R9 stream select");
      else if (lfsr[3:0] == 4'd1) wr(2'd3, lfsr[15:8], "R8 stream spare");
      else                        wr({1'b0, lfsr[4]}, lfsr[15:8], "R2_R3_R6_R7 stream load");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule